// File: doc/BRIEF.md
# Bus Reset Watcher and Interrupt Vector Driver

This block is the bus-facing control slice of a parallel I/O port on an 8-bit bus. Its M1 strobe marks opcode fetch and interrupt acknowledge, and its RD and IORQ strobes mark reads and I/O cycles. The block samples the active-low M1, RD and IORQ strobes on every rising clock edge. If an M1 cycle completes with neither RD nor IORQ ever seen, the block puts the port into its reset state. That way one external gate can reset the peripheral without a power cycle. The port leaves the reset state, whether it got there from power-on or from the strobe condition, only when the CPU writes a control word.

A control word whose lowest bit is clear is an interrupt vector. Its upper seven bits are kept in a vector register. Any other control word still releases the reset state, but it belongs to a separate mode decoder and leaves the vector alone.

The port's interrupt request takes part in a daisy chain. When an acknowledge cycle arrives, the block answers only if it holds a pending request and its chain input is high. It then drives the vector, with bit 0 forced to zero, and marks itself in service. While it has a request pending or in service, it pulls its chain output low. This stops lower-priority devices from answering.

Top module: `pio_busctl`

## Requirements
- R1: While `por_n` is low, `held_reset` is 1, `vec_out` is 8'h00 and `vec_oe` is 0. The vector register also returns to zero.
- R2: An M1 cycle during which RD and IORQ are never sampled low sets `held_reset` at the first edge that samples `m1_n` high again. While M1 is still sampled low, `held_reset` does not rise. This also holds for an M1 that is only one cycle long.
- R3: An M1 cycle during which RD or IORQ is sampled low at any edge does not cause a reset.
- R4: A control write is an edge sampling `cs_n`=0, `ctl_sel`=1, `iorq_n`=0, `rd_n`=1, `m1_n`=1. It clears `held_reset` after that edge, whatever the value of data bit 0. A write with `ctl_sel`=0 leaves `held_reset` set. Once set, `held_reset` stays set until such a control write.
- R5: A control write with `wr_data[0]`=0 stores `wr_data[7:1]`. From the next cycle, `vec_out` equals {stored bits, 1'b0}.
- R6: A control write with `wr_data[0]`=1 leaves `vec_out` unchanged.
- R7: A reset from the M1 condition of R2 keeps the stored vector.
- R8: An acknowledge cycle is sampled as `m1_n`=0 and `iorq_n`=0. At the first such edge, with `chain_in`=1 and a request pending, `vec_oe` rises. It stays high for as long as the acknowledge is sampled, and falls at the first edge after the acknowledge ends. Bit 0 of `vec_out` is 0 whenever `vec_oe` is high.
- R9: An acknowledge sampled with `chain_in`=0 does not raise `vec_oe`.
- R10: `chain_out` is combinationally `chain_in` AND NOT (request pending OR in service). A request is pending when `port_irq`=1, the block is not in reset and it is not in service.
- R11: While `held_reset` is 1, `port_irq` is masked: `vec_oe` stays 0 and `chain_out` equals `chain_in`.
- R12: The in-service state ends at the first edge outside an acknowledge that samples `port_irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes sampled on rising edge |
| por_n | input | 1 | Power-on reset, active low |
| cs_n | input | 1 | Chip enable, active low |
| ctl_sel | input | 1 | 1 selects the control register, 0 the data port |
| m1_n | input | 1 | M1 strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| wr_data | input | 8 | Byte written by the CPU |
| port_irq | input | 1 | Interrupt request from the port logic |
| chain_in | input | 1 | Daisy-chain enable from higher-priority devices |
| vec_out | output | 8 | Vector byte, bit 0 always zero |
| vec_oe | output | 1 | Data-bus output enable for the vector |
| held_reset | output | 1 | Port is in its reset state |
| chain_out | output | 1 | Daisy-chain enable to lower-priority devices |

## Verification
The assertions assume that the strobes and data are synchronous to `clk` and steady across each rising edge. They also assume that a control write never overlaps an M1 cycle. They read a rise of `vec_oe` as proof that `chain_in` was high at the edge before, which holds only if the chain input does not move between the acknowledge sample and the driving cycle. The bench changes inputs only on the falling edge and never combines a control write with M1 low. It pulses `por_n` only while every strobe is idle.

// File: rtl/pio_busctl_pkg.sv
package pio_busctl_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic m1;
    logic rd;
    logic iorq;
    logic cs;
  } strobe_t;

  // active-high view of the active-low pins
  function automatic strobe_t strobe_view(input logic m1_n, input logic rd_n,
                                          input logic iorq_n, input logic cs_n);
    strobe_t s;
    s.m1   = ~m1_n;
    s.rd   = ~rd_n;
    s.iorq = ~iorq_n;
    s.cs   = ~cs_n;
    return s;
  endfunction

  function automatic logic is_ack(input strobe_t s);
    return s.m1 & s.iorq;
  endfunction

  function automatic logic is_ctl_write(input strobe_t s, input logic sel);
    return s.cs & sel & s.iorq & ~s.rd & ~s.m1;
  endfunction

  // low bit clear marks a vector word
  function automatic logic is_vector_word(input logic [BYTE_W-1:0] d);
    return ~d[0];
  endfunction

  function automatic logic [BYTE_W-1:0] vector_image(input logic [BYTE_W-2:0] v);
    return {v, 1'b0};
  endfunction

endpackage

// File: rtl/pio_m1_watch.sv
module pio_m1_watch
  import pio_busctl_pkg::*;
(
  input  logic    clk,
  input  logic    por_n,
  input  strobe_t stb,
  input  logic    ctl_wr,
  output logic    m1_reset,
  output logic    in_reset
);

  logic m1_q;
  logic clean_q;
  logic clean_now;
  logic m1_end;

  // a new M1 starts clean; any RD/IORQ inside it spoils it
  assign clean_now = (m1_q ? clean_q : 1'b1) & ~(stb.rd | stb.iorq);
  assign m1_end    = ~stb.m1 & m1_q;
  assign m1_reset  = m1_end & clean_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m1_q    <= 1'b0;
      clean_q <= 1'b0;
    end else begin
      m1_q <= stb.m1;
      if (stb.m1) clean_q <= clean_now;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        in_reset <= 1'b1;
    else if (m1_reset) in_reset <= 1'b1;
    else if (ctl_wr)   in_reset <= 1'b0;
  end

endmodule

// File: rtl/pio_vec_reg.sv
module pio_vec_reg
  import pio_busctl_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wr_data,
  output logic          vec_wr,
  output logic [DW-1:0] vec_byte
);

  localparam int unsigned VW = DW - 1;

  logic [VW-1:0] vec_q;

  assign vec_wr = ctl_wr & is_vector_word(wr_data);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      vec_q <= '0;
    else if (vec_wr) vec_q <= wr_data[DW-1:1];
  end

  assign vec_byte = {vec_q, 1'b0};

endmodule

// File: rtl/pio_irq_chain.sv
module pio_irq_chain (
  input  logic clk,
  input  logic por_n,
  input  logic ack,
  input  logic in_reset,
  input  logic m1_reset,
  input  logic port_irq,
  input  logic chain_in,
  output logic pending,
  output logic in_service,
  output logic drive,
  output logic chain_out
);

  logic req;
  logic win;

  assign req       = port_irq & ~in_reset;
  assign pending   = req & ~in_service;
  assign chain_out = chain_in & ~pending & ~in_service;
  assign win       = ack & chain_in & pending;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     in_service <= 1'b0;
    else if (m1_reset || in_reset)  in_service <= 1'b0;
    else if (win)                   in_service <= 1'b1;
    else if (!port_irq && !ack)     in_service <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) drive <= 1'b0;
    else        drive <= ack & chain_in & (pending | (in_service & drive));
  end

endmodule

// File: rtl/pio_busctl.sv
module pio_busctl
  import pio_busctl_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          cs_n,
  input  logic          ctl_sel,
  input  logic          m1_n,
  input  logic          rd_n,
  input  logic          iorq_n,
  input  logic [DW-1:0] wr_data,
  input  logic          port_irq,
  input  logic          chain_in,
  output logic [DW-1:0] vec_out,
  output logic          vec_oe,
  output logic          held_reset,
  output logic          chain_out
);

  strobe_t stb;
  logic    ctl_wr_w;
  logic    vec_wr_w;
  logic    m1_reset_w;
  logic    ack_w;
  logic    pending_w;
  logic    in_service_w;

  assign stb      = strobe_view(m1_n, rd_n, iorq_n, cs_n);
  assign ctl_wr_w = is_ctl_write(stb, ctl_sel);
  assign ack_w    = is_ack(stb);

  pio_m1_watch u_watch (
    .clk      (clk),
    .por_n    (por_n),
    .stb      (stb),
    .ctl_wr   (ctl_wr_w),
    .m1_reset (m1_reset_w),
    .in_reset (held_reset)
  );

  pio_vec_reg #(.DW(DW)) u_vec (
    .clk      (clk),
    .por_n    (por_n),
    .ctl_wr   (ctl_wr_w),
    .wr_data  (wr_data),
    .vec_wr   (vec_wr_w),
    .vec_byte (vec_out)
  );

  pio_irq_chain u_chain (
    .clk        (clk),
    .por_n      (por_n),
    .ack        (ack_w),
    .in_reset   (held_reset),
    .m1_reset   (m1_reset_w),
    .port_irq   (port_irq),
    .chain_in   (chain_in),
    .pending    (pending_w),
    .in_service (in_service_w),
    .drive      (vec_oe),
    .chain_out  (chain_out)
  );

endmodule

// File: rtl/pio_busctl_chk.sv
module pio_busctl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          por_n,
  input logic          m1_n,
  input logic [DW-1:0] wr_data,
  input logic          chain_in,
  input logic [DW-1:0] vec_out,
  input logic          vec_oe,
  input logic          held_reset,
  input logic          chain_out,
  input logic          ctl_wr_w,
  input logic          vec_wr_w,
  input logic          m1_reset_w,
  input logic          in_service_w
);

  p_m1_reset_r2: assert property (@(posedge clk) disable iff (!por_n)
    m1_reset_w |=> held_reset);

  p_no_early_reset_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(held_reset) |-> $past(m1_n));

  p_release_r4: assert property (@(posedge clk) disable iff (!por_n)
    (ctl_wr_w && !m1_reset_w) |=> !held_reset);

  p_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    (held_reset && !ctl_wr_w) |=> held_reset);

  p_load_r5: assert property (@(posedge clk) disable iff (!por_n)
    vec_wr_w |=> (vec_out == {$past(wr_data[DW-1:1]), 1'b0}));

  p_keep_r6: assert property (@(posedge clk) disable iff (!por_n)
    (ctl_wr_w && wr_data[0]) |=> $stable(vec_out));

  p_bit0_r8: assert property (@(posedge clk) disable iff (!por_n)
    vec_oe |-> !vec_out[0]);

  p_chain_gate_r9: assert property (@(posedge clk) disable iff (!por_n)
    vec_oe |-> $past(chain_in));

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!por_n)
    in_service_w |-> !chain_out);

  p_mask_r11: assert property (@(posedge clk) disable iff (!por_n)
    held_reset |-> (!vec_oe && (chain_out == chain_in)));

endmodule

bind pio_busctl pio_busctl_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .m1_n         (m1_n),
  .wr_data      (wr_data),
  .chain_in     (chain_in),
  .vec_out      (vec_out),
  .vec_oe       (vec_oe),
  .held_reset   (held_reset),
  .chain_out    (chain_out),
  .ctl_wr_w     (ctl_wr_w),
  .vec_wr_w     (vec_wr_w),
  .m1_reset_w   (m1_reset_w),
  .in_service_w (in_service_w)
);

// File: tb/sim_pio_busctl.sv
`timescale 1ns/1ps
module sim_pio_busctl;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       cs_n = 1'b1, ctl_sel = 1'b0;
  logic       m1_n = 1'b1, rd_n = 1'b1, iorq_n = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic       port_irq = 1'b0, chain_in = 1'b1;
  logic [7:0] vec_out;
  logic       vec_oe, held_reset, chain_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pio_busctl u0 (
    .clk(clk), .por_n(por_n), .cs_n(cs_n), .ctl_sel(ctl_sel),
    .m1_n(m1_n), .rd_n(rd_n), .iorq_n(iorq_n), .wr_data(wr_data),
    .port_irq(port_irq), .chain_in(chain_in),
    .vec_out(vec_out), .vec_oe(vec_oe), .held_reset(held_reset),
    .chain_out(chain_out)
  );

  // strobe codes {m1_n, rd_n, iorq_n, cs_n, ctl_sel}
  localparam logic [4:0] IDL = 5'b11110;
  localparam logic [4:0] CWR = 5'b11001;
  localparam logic [4:0] DWR = 5'b11000;
  localparam logic [4:0] ACK = 5'b01010;
  localparam logic [4:0] M1O = 5'b01110;
  localparam logic [4:0] M1R = 5'b00110;

  // {req id, strobes, data, irq, chain, exp oe, exp rst, exp chain, exp vec}
  localparam int NROW = 22;
  localparam logic [29:0] TBL [NROW] = '{
    {4'd11, IDL, 8'h00, 2'b01, 3'b011, 8'h00},  // R11 idle in reset
    {4'd11, IDL, 8'h00, 2'b11, 3'b011, 8'h00},  // R11 irq masked
    {4'd4,  DWR, 8'hA5, 2'b01, 3'b011, 8'h00},  // R4 data write keeps reset
    {4'd6,  CWR, 8'h5B, 2'b01, 3'b001, 8'h00},  // R6 mode word releases, no load
    {4'd5,  CWR, 8'hA6, 2'b01, 3'b001, 8'hA6},  // R5 vector load
    {4'd10, IDL, 8'h00, 2'b11, 3'b000, 8'hA6},  // R10 pending blocks chain
    {4'd10, IDL, 8'h00, 2'b10, 3'b000, 8'hA6},  // R10 chain_in low
    {4'd9,  ACK, 8'h00, 2'b10, 3'b000, 8'hA6},  // R9 ack without priority
    {4'd3,  IDL, 8'h00, 2'b11, 3'b000, 8'hA6},  // R3 ack M1 is no reset
    {4'd8,  ACK, 8'h00, 2'b11, 3'b100, 8'hA6},  // R8 drive vector
    {4'd8,  ACK, 8'h00, 2'b11, 3'b100, 8'hA6},  // R8 still driving
    {4'd10, IDL, 8'h00, 2'b11, 3'b000, 8'hA6},  // R10 in service blocks
    {4'd12, IDL, 8'h00, 2'b01, 3'b001, 8'hA6},  // R12 service ends
    {4'd2,  M1O, 8'h00, 2'b01, 3'b001, 8'hA6},  // R2 no reset during M1
    {4'd2,  M1O, 8'h00, 2'b01, 3'b001, 8'hA6},  // R2
    {4'd7,  IDL, 8'h00, 2'b01, 3'b011, 8'hA6},  // R2 reset after M1, R7 vector kept
    {4'd11, IDL, 8'h00, 2'b11, 3'b011, 8'hA6},  // R11 masked again
    {4'd5,  CWR, 8'h3C, 2'b01, 3'b001, 8'h3C},  // R5 reload
    {4'd3,  M1O, 8'h00, 2'b01, 3'b001, 8'h3C},  // R3
    {4'd3,  M1R, 8'h00, 2'b01, 3'b001, 8'h3C},  // R3 read inside M1
    {4'd3,  M1O, 8'h00, 2'b01, 3'b001, 8'h3C},  // R3
    {4'd3,  IDL, 8'h00, 2'b01, 3'b001, 8'h3C}   // R3 no reset
  };

  task automatic drive(input logic [4:0] s, input logic [7:0] d,
                       input logic irq, input logic ch);
    {m1_n, rd_n, iorq_n, cs_n, ctl_sel} = s;
    wr_data = d; port_irq = irq; chain_in = ch;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [2:0] got3, input logic [2:0] exp3,
                       input logic [7:0] gotv, input logic [7:0] expv);
    n_cmp++;
    if (got3 !== exp3 || gotv !== expv) begin
      n_bad++;
      $display("FAIL %s: {oe,rst,chain}=%b vec=%h expected %b vec=%h",
               tag, got3, gotv, exp3, expv);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    drive(IDL, 8'h00, 1'b0, 1'b1);
    @(negedge clk);
    // R1 during power-on reset
    check("R1", {vec_oe, held_reset, chain_out}, 3'b011, vec_out, 8'h00);
    step();
    por_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i][25:21], TBL[i][20:13], TBL[i][12], TBL[i][11]);
      step();
      check($sformatf("R%0d row %0d", TBL[i][29:26], i),
            {vec_oe, held_reset, chain_out}, TBL[i][10:8], vec_out, TBL[i][7:0]);
    end

    // R2 / R7: one-cycle M1 with no RD or IORQ
    drive(M1O, 8'h00, 1'b0, 1'b1); step();
    check("R2 short M1 pending", {vec_oe, held_reset, chain_out}, 3'b001, vec_out, 8'h3C);
    drive(IDL, 8'h00, 1'b0, 1'b1); step();
    check("R2 short M1 reset R7", {vec_oe, held_reset, chain_out}, 3'b011, vec_out, 8'h3C);

    // R11: acknowledge while in reset drives nothing
    drive(ACK, 8'h00, 1'b1, 1'b1); step();
    check("R11 ack in reset", {vec_oe, held_reset, chain_out}, 3'b011, vec_out, 8'h3C);
    drive(IDL, 8'h00, 1'b0, 1'b1); step();

    // R3: IORQ seen only in the last M1 cycle
    drive(CWR, 8'h81, 1'b0, 1'b1); step();
    check("R4 odd word release R6", {vec_oe, held_reset, chain_out}, 3'b001, vec_out, 8'h3C);
    drive(M1O, 8'h00, 1'b0, 1'b1); step();
    drive(ACK, 8'h00, 1'b0, 1'b1); step();
    drive(IDL, 8'h00, 1'b0, 1'b1); step();
    check("R3 late IORQ", {vec_oe, held_reset, chain_out}, 3'b001, vec_out, 8'h3C);

    // R8: vector drop after acknowledge ends, different vector
    drive(CWR, 8'hFE, 1'b0, 1'b1); step();
    drive(IDL, 8'h00, 1'b1, 1'b1); step();
    drive(ACK, 8'h00, 1'b1, 1'b1); step();
    check("R8 drive FE", {vec_oe, held_reset, chain_out}, 3'b100, vec_out, 8'hFE);
    drive(IDL, 8'h00, 1'b1, 1'b1); step();
    check("R8 drop after ack", {vec_oe, held_reset, chain_out}, 3'b000, vec_out, 8'hFE);

    // R1: power-on reset mid-run clears everything
    por_n = 1'b0;
    #1;
    check("R1 por mid-run", {vec_oe, held_reset, chain_out}, 3'b011, vec_out, 8'h00);
    step();
    por_n = 1'b1;
    drive(IDL, 8'h00, 1'b0, 1'b1); step();
    check("R1 after por", {vec_oe, held_reset, chain_out}, 3'b011, vec_out, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule